// File: doc/BRIEF.md
# Supply Undervoltage Fault Supervisor

This block sits between two undervoltage comparators and the gate-driver and charge-pump controls of a motor driver. One comparator flags the main supply below its threshold. The other flags the charge-pump rail below its threshold. The block passes both flags through a synchronizer. It then decides on each cycle whether the gate drivers may switch and whether the charge pump may run, and it pulls an active-low fault pin while either condition is live.

The outputs that block the drivers and the fault pin follow the live condition, so normal operation returns by itself once the supply recovers. Three status bits keep a record for a register interface: a summary fault bit and one bit for each cause. These bits stay set until software issues a clear strobe, or until the enable pin is held low long enough and then released. A strap selects between register mode and hardware mode. In register mode, a disable bit can switch off charge-pump undervoltage protection. In hardware mode that protection is always active.

Top module: `uv_supervisor`

## Requirements
- R1: Two clock edges after `main_uv_raw` goes high, `drv_en`, `cp_en` and `fault_n` are all 0.
- R2: Two clock edges after `cp_uv_raw` goes high (protection active, main supply good), `drv_en` = 0 and `fault_n` = 0, while `cp_en` stays 1.
- R3: Two clock edges after every active undervoltage flag returns low, `drv_en`, `cp_en` and `fault_n` are 1 again, with no other input required.
- R4: One edge after a condition is seen by the logic, `stat_fault` and that cause's bit (`stat_main_uv` or `stat_cp_uv`) are 1. They stay 1 after the condition ends. All three are 0 after reset.
- R5: A one-cycle high on `clr_faults` while no condition is present clears all three status bits at the next edge.
- R6: A clear that lands in the same cycle as a present condition leaves that condition's bit and `stat_fault` set; the setting wins.
- R7: If `en_pin` is held low for at least `RST_LOW_CYC` synchronized cycles and then returns high, all status bits clear, provided no condition is present.
- R8: If `en_pin` is low for fewer than `RST_LOW_CYC` cycles, the status bits do not change.
- R9: With `reg_mode` = 1 and `cp_uv_dis` = 1, a charge-pump undervoltage changes no output and sets no status bit.
- R10: With `reg_mode` = 0, `cp_uv_dis` is ignored: a charge-pump undervoltage still blocks the drivers, pulls `fault_n` low and sets `stat_cp_uv`.
- R11: A raw flag change has no effect on the outputs after only one clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| main_uv_raw | input | 1 | Main supply undervoltage flag, asynchronous |
| cp_uv_raw | input | 1 | Charge-pump rail undervoltage flag, asynchronous |
| clr_faults | input | 1 | One-cycle clear strobe for the status bits |
| en_pin | input | 1 | Enable pin; a long low pulse clears the status bits |
| cp_uv_dis | input | 1 | Disables charge-pump undervoltage protection (register mode only) |
| reg_mode | input | 1 | 1 = register mode, 0 = hardware strap mode |
| drv_en | output | 1 | Gate-driver enable |
| cp_en | output | 1 | Charge-pump enable |
| fault_n | output | 1 | Active-low fault pin |
| stat_fault | output | 1 | Sticky summary fault bit |
| stat_main_uv | output | 1 | Sticky main-supply undervoltage bit |
| stat_cp_uv | output | 1 | Sticky charge-pump undervoltage bit |

## Verification
The clear strobe and a freshly synchronized undervoltage can reach the status register in the same cycle. The bench provokes this by raising the main-supply flag and then firing the clear strobe exactly when the flag leaves the synchronizer. It then expects the cause bit and the summary bit to be set one edge later, which shows that setting wins over clearing. Clearing while the charge-pump condition is still present is checked the same way.

// File: rtl/uvs_pkg.sv
package uvs_pkg;

   typedef struct packed {
      logic fault;
      logic main_uv;
      logic cp_uv;
   } uvs_stat_t;

   localparam int unsigned UVS_MIN_SYNC = 2;

endpackage

// File: rtl/uvs_sync.sv
module uvs_sync #(
   parameter int unsigned      WIDTH   = 1,
   parameter int unsigned      STAGES  = 2,
   parameter logic [WIDTH-1:0] RST_VAL = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);

   logic [WIDTH-1:0] stg [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg[0] <= RST_VAL;
      else        stg[0] <= d;
   end

   for (genvar i = 1; i < STAGES; i++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) stg[i] <= RST_VAL;
         else        stg[i] <= stg[i-1];
      end
   end

   assign q = stg[STAGES-1];

endmodule

// File: rtl/uvs_low_pulse.sv
module uvs_low_pulse #(
   parameter int unsigned MIN_LOW = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pin_s,
   output logic pulse
);

   localparam int unsigned CNT_W = $clog2(MIN_LOW + 1);
   localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(MIN_LOW);

   logic [CNT_W-1:0] low_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                low_cnt <= '0;
      else if (pin_s)            low_cnt <= '0;
      else if (low_cnt != CNT_MAX) low_cnt <= low_cnt + 1'b1;
   end

   assign pulse = pin_s && (low_cnt == CNT_MAX);

endmodule

// File: rtl/uvs_status.sv
module uvs_status
   import uvs_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      main_uv,
   input  logic      cp_uv,
   input  logic      clr,
   output uvs_stat_t stat
);

   uvs_stat_t nxt;

   always_comb begin
      nxt.main_uv = (stat.main_uv & ~clr) | main_uv;
      nxt.cp_uv   = (stat.cp_uv   & ~clr) | cp_uv;
      nxt.fault   = (stat.fault   & ~clr) | main_uv | cp_uv;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stat <= '0;
      else        stat <= nxt;
   end

endmodule

// File: rtl/uv_supervisor.sv
module uv_supervisor
   import uvs_pkg::*;
#(
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned RST_LOW_CYC = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic main_uv_raw,
   input  logic cp_uv_raw,
   input  logic clr_faults,
   input  logic en_pin,
   input  logic cp_uv_dis,
   input  logic reg_mode,
   output logic drv_en,
   output logic cp_en,
   output logic fault_n,
   output logic stat_fault,
   output logic stat_main_uv,
   output logic stat_cp_uv
);

   if (SYNC_STAGES < UVS_MIN_SYNC) begin : g_bad_sync
      $error("uv_supervisor: SYNC_STAGES below minimum");
   end
   if (RST_LOW_CYC < 1) begin : g_bad_low
      $error("uv_supervisor: RST_LOW_CYC must be at least 1");
   end

   logic [1:0] flags_q;
   logic       main_q;
   logic       cp_q;
   logic       en_q;
   logic       cp_eff;
   logic       rst_pulse;
   logic       clr_any;
   uvs_stat_t  stat;

   uvs_sync #(.WIDTH(2), .STAGES(SYNC_STAGES), .RST_VAL(2'b00)) u_flag_sync (
      .clk(clk), .rst_n(rst_n), .d({main_uv_raw, cp_uv_raw}), .q(flags_q)
   );

   uvs_sync #(.WIDTH(1), .STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_en_sync (
      .clk(clk), .rst_n(rst_n), .d(en_pin), .q(en_q)
   );

   assign main_q = flags_q[1];
   assign cp_q   = flags_q[0];

   // hardware mode forces charge-pump protection on
   assign cp_eff = cp_q & ~(reg_mode & cp_uv_dis);

   uvs_low_pulse #(.MIN_LOW(RST_LOW_CYC)) u_low_pulse (
      .clk(clk), .rst_n(rst_n), .pin_s(en_q), .pulse(rst_pulse)
   );

   assign clr_any = clr_faults | rst_pulse;

   uvs_status u_status (
      .clk(clk), .rst_n(rst_n), .main_uv(main_q), .cp_uv(cp_eff),
      .clr(clr_any), .stat(stat)
   );

   assign drv_en       = ~(main_q | cp_eff);
   assign cp_en        = ~main_q;
   assign fault_n      = ~(main_q | cp_eff);
   assign stat_fault   = stat.fault;
   assign stat_main_uv = stat.main_uv;
   assign stat_cp_uv   = stat.cp_uv;

endmodule

// File: rtl/uv_supervisor_chk.sv
module uv_supervisor_chk (
   input logic clk,
   input logic rst_n,
   input logic main_q,
   input logic cp_q,
   input logic cp_uv_dis,
   input logic reg_mode,
   input logic clr_any,
   input logic drv_en,
   input logic cp_en,
   input logic fault_n,
   input logic stat_fault,
   input logic stat_main_uv,
   input logic stat_cp_uv
);

   assert_main_blocks_R1: assert property (@(posedge clk) disable iff (!rst_n)
      main_q |-> (!drv_en && !cp_en && !fault_n));

   assert_cp_keeps_pump_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (cp_q && !main_q && !(reg_mode && cp_uv_dis)) |-> (!drv_en && cp_en && !fault_n));

   assert_recover_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (!main_q && !cp_q) |-> (drv_en && cp_en && fault_n));

   assert_sticky_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
      main_q |=> (stat_main_uv && stat_fault));

   assert_hold_no_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_main_uv && !clr_any) |=> stat_main_uv);

   assert_set_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (cp_q && clr_any && !(reg_mode && cp_uv_dis)) |=> (stat_cp_uv && stat_fault));

   assert_dis_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (cp_q && !main_q && reg_mode && cp_uv_dis) |-> (drv_en && fault_n));

   assert_hw_forced_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (cp_q && !reg_mode) |-> (!drv_en && !fault_n));

endmodule

bind uv_supervisor uv_supervisor_chk u_chk (
   .clk(clk), .rst_n(rst_n), .main_q(main_q), .cp_q(cp_q),
   .cp_uv_dis(cp_uv_dis), .reg_mode(reg_mode), .clr_any(clr_any),
   .drv_en(drv_en), .cp_en(cp_en), .fault_n(fault_n),
   .stat_fault(stat_fault), .stat_main_uv(stat_main_uv), .stat_cp_uv(stat_cp_uv)
);

// File: tb/uv_supervisor_test.sv
`timescale 1ns/1ps
module uv_supervisor_test;

   localparam int CLK_PERIOD = 10;
   localparam int LOW_CYC    = 8;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic main_uv_raw = 1'b0, cp_uv_raw = 1'b0, clr_faults = 1'b0;
   logic en_pin = 1'b1, cp_uv_dis = 1'b0, reg_mode = 1'b1;
   logic drv_en, cp_en, fault_n, stat_fault, stat_main_uv, stat_cp_uv;

   always #(CLK_PERIOD/2) clk = ~clk;

   uv_supervisor #(.SYNC_STAGES(2), .RST_LOW_CYC(LOW_CYC)) uut (
      .clk(clk), .rst_n(rst_n), .main_uv_raw(main_uv_raw), .cp_uv_raw(cp_uv_raw),
      .clr_faults(clr_faults), .en_pin(en_pin), .cp_uv_dis(cp_uv_dis),
      .reg_mode(reg_mode), .drv_en(drv_en), .cp_en(cp_en), .fault_n(fault_n),
      .stat_fault(stat_fault), .stat_main_uv(stat_main_uv), .stat_cp_uv(stat_cp_uv)
   );

   typedef struct {
      string      tag;
      logic [5:0] exp;
   } item_t;

   item_t q[$];
   int    total = 0;
   int    bad   = 0;
   bit    done  = 0;

   // expected order: {drv_en, cp_en, fault_n, stat_fault, stat_main_uv, stat_cp_uv}
   task automatic expect_out(input string tag, input logic [5:0] e);
      item_t it;
      it.tag = tag;
      it.exp = e;
      q.push_back(it);
      wait (q.size() == 0);
   endtask

   task automatic step(input int n);
      repeat (n) @(negedge clk);
   endtask

   initial begin : monitor
      item_t it;
      logic [5:0] act;
      forever begin
         wait (q.size() > 0);
         it  = q.pop_front();
         act = {drv_en, cp_en, fault_n, stat_fault, stat_main_uv, stat_cp_uv};
         total++;
         if (act !== it.exp) begin
            bad++;
            $display("FAIL %s actual=%b expected=%b at %0t", it.tag, act, it.exp, $time);
         end
      end
   end

   initial begin : watchdog
      #(CLK_PERIOD * 200000);
      if (!done) begin
         bad++;
         total++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin : driver
      step(3);
      rst_n = 1'b1;
      step(3);
      expect_out("R4 reset", 6'b111_000);

      // main supply undervoltage
      main_uv_raw = 1'b1;
      step(1);
      expect_out("R11", 6'b111_000);
      step(1);
      expect_out("R1", 6'b000_000);
      step(1);
      expect_out("R4 set", 6'b000_110);
      main_uv_raw = 1'b0;
      step(2);
      expect_out("R3 main", 6'b111_110);
      step(3);
      expect_out("R4 hold", 6'b111_110);
      clr_faults = 1'b1;
      step(1);
      clr_faults = 1'b0;
      expect_out("R5", 6'b111_000);

      // charge-pump undervoltage
      cp_uv_raw = 1'b1;
      step(3);
      expect_out("R2", 6'b010_101);
      clr_faults = 1'b1;
      step(1);
      clr_faults = 1'b0;
      expect_out("R6 cp present", 6'b010_101);
      cp_uv_raw = 1'b0;
      step(2);
      expect_out("R3 cp", 6'b111_101);
      clr_faults = 1'b1;
      step(1);
      clr_faults = 1'b0;
      expect_out("R5 cp", 6'b111_000);

      // register mode with protection disabled
      cp_uv_dis = 1'b1;
      cp_uv_raw = 1'b1;
      step(4);
      expect_out("R9", 6'b111_000);
      cp_uv_raw = 1'b0;
      step(3);

      // hardware mode ignores the disable bit
      reg_mode  = 1'b0;
      cp_uv_raw = 1'b1;
      step(3);
      expect_out("R10", 6'b010_101);
      cp_uv_raw = 1'b0;
      step(3);
      expect_out("R10 after", 6'b111_101);

      // short enable glitch
      en_pin = 1'b0;
      step(LOW_CYC - 3);
      en_pin = 1'b1;
      step(6);
      expect_out("R8", 6'b111_101);

      // long enable pulse
      en_pin = 1'b0;
      step(LOW_CYC + 3);
      en_pin = 1'b1;
      step(6);
      expect_out("R7", 6'b111_000);

      // clear and new set land in the same cycle
      reg_mode    = 1'b1;
      cp_uv_dis   = 1'b0;
      main_uv_raw = 1'b1;
      step(2);
      clr_faults  = 1'b1;
      step(1);
      clr_faults  = 1'b0;
      expect_out("R6 same cycle", 6'b000_110);
      main_uv_raw = 1'b0;
      step(3);
      expect_out("R3 final", 6'b111_110);

      // both conditions together
      main_uv_raw = 1'b1;
      cp_uv_raw   = 1'b1;
      step(3);
      expect_out("R1 both", 6'b000_111);
      main_uv_raw = 1'b0;
      cp_uv_raw   = 1'b0;
      step(3);

      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule